// File: doc/BRIEF.md
# Ratio-Selectable System Clock Divider with Output Gating

This block takes one fast base clock that runs at twice the processor clock rate. From it, the block makes four groups of system clocks: a half-rate reference clock, a mid-rate bus clock, a PCI-rate clock and a slow interrupt-controller clock. A single fast/slow ratio bit picks between two ratio sets. With the bit at 1 (the 133 setting), the groups run at CPU/2, CPU/4 and CPU/8. With the bit at 0 (the 100 setting), they run at 2×CPU/3, CPU/3 and CPU/6. The reference group always runs at CPU/2.

The ratio bit is bit 3 of a 4-bit frequency code. A code-source input chooses where that code comes from: the already-latched strap code or the register code. A shared frame counter keeps all groups in step, so every group rises together at the start of each frame. A new ratio takes effect only at a frame boundary.

Each copy of each group has its own enable. A disabled copy is driven low, and an enable change only takes effect while that copy is low. A 2-bit global mode field selects one of four behaviours:
- run: plain division.
- spread: the same digital division; the modulation lives in the oscillator, which is outside this block.
- bypass: every output follows a test clock input, gated by its enable.
- hi-z: the shared output-enable is dropped.

Top module: `ratio_clk_div`

## Requirements
- R1: While reset is asserted, every clock output is low and `oe_o` is high.
- R2: The reference output has a period of 4 base cycles and is high for 2 of them, with either ratio setting.
- R3: With the selected code's bit 3 at 1, the mid, PCI and interrupt outputs have periods of 4, 8 and 16 base cycles, high for 2, 4 and 8 cycles.
- R4: With the selected code's bit 3 at 0, the mid, PCI and interrupt outputs have periods of 3, 6 and 12 base cycles, high for 2, 3 and 6 cycles.
- R5: `code_src_i` = 1 selects `reg_code_i` and 0 selects `strap_code_i`; the selected code appears on `sel_code_o`, and its bit 3 is the ratio bit.
- R6: A copy whose enable is 0 stays low, while `oe_o` stays high and the other copies keep running.
- R7: An enable change is applied only during a low phase, so every high pulse of a gated output has the full high length of its group.
- R8: Every rising edge of the interrupt clock coincides with a rising edge of the reference, mid and PCI clocks.
- R9: A change of the ratio bit takes effect only at a frame boundary (16 base cycles in the 133 setting, 12 in the 100 setting), after which the new ratios hold.
- R10: Global mode 2'b10 (spread) divides exactly as mode 2'b00 (run).
- R11: Global mode 2'b01 (bypass) makes every output equal to `test_clk_i` AND that output's enable.
- R12: Global mode 2'b11 (hi-z) drives `oe_o` low; modes 00, 01 and 10 drive it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock, twice the processor clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_code_i | input | CODE_W | Latched strap frequency code |
| reg_code_i | input | CODE_W | Register frequency code |
| code_src_i | input | 1 | 1 selects register code, 0 selects strap code |
| gmode_i | input | 2 | Global mode: 00 run, 01 bypass, 10 spread, 11 hi-z |
| test_clk_i | input | 1 | Bypass test clock source |
| ref_en_i | input | 1 | Reference output enable |
| mid_en_i | input | N_MID | Mid-rate output enables |
| pci_en_i | input | N_PCI | PCI-rate output enables |
| apic_en_i | input | N_APIC | Interrupt-clock output enables |
| sel_code_o | output | CODE_W | Frequency code in use |
| oe_o | output | 1 | Shared output-driver enable |
| ref_o | output | 1 | Reference clock |
| mid_o | output | N_MID | Mid-rate clocks |
| pci_o | output | N_PCI | PCI-rate clocks |
| apic_o | output | N_APIC | Interrupt-controller clocks |

## Verification
Each divided output is registered one base cycle after its divider phase. A ratio change lands at the next frame boundary, at most 16 base cycles later. An enable change lands at the next low phase. The bench therefore waits 40 base cycles after any ratio or enable change before it samples. It then counts rising edges and high samples over a 48-cycle window, which holds a whole number of periods in both settings, so the expected counts do not depend on where the window starts. Bypass, hi-z and code selection act on the outputs without a register, and they are checked 1 ns after the input changes.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

   typedef enum logic [1:0] {
      GM_RUN    = 2'b00,
      GM_BYPASS = 2'b01,
      GM_SPREAD = 2'b10,
      GM_HIZ    = 2'b11
   } gmode_e;

   localparam int NGRP     = 4;
   localparam int GRP_REF  = 0;
   localparam int GRP_MID  = 1;
   localparam int GRP_PCI  = 2;
   localparam int GRP_APIC = 3;

   // period of a group in base cycles; c = base cycles per processor cycle
   function automatic int grp_period(input int grp, input bit fast, input int c);
      case (grp)
         GRP_REF: return 2 * c;
         GRP_MID: return fast ? 2 * c : (3 * c) / 2;
         GRP_PCI: return fast ? 4 * c : 3 * c;
         default: return fast ? 8 * c : 6 * c;
      endcase
   endfunction

   // frame = least common multiple of all periods of one setting
   function automatic int frame_len(input bit fast, input int c);
      return fast ? 8 * c : 6 * c;
   endfunction

   // high phase is the longer half for odd periods
   function automatic int high_len(input int p);
      return p - p / 2;
   endfunction

endpackage

// File: rtl/rcd_seq.sv
module rcd_seq
   import rcd_pkg::*;
#(
   parameter int   C          = 2,
   parameter int   W          = 4,
   parameter logic RESET_FAST = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic fast_sel_i,
   output logic fast_q_o,
   output logic wrap_o
);

   localparam logic [W-1:0] LAST_FAST = W'(frame_len(1'b1, C) - 1);
   localparam logic [W-1:0] LAST_SLOW = W'(frame_len(1'b0, C) - 1);

   if (frame_len(1'b1, C) > (1 << W)) begin : g_bad_w
      $error("rcd_seq: W too narrow for frame length");
   end

   logic [W-1:0] frame_q;
   logic         fast_q;

   assign wrap_o   = (frame_q == (fast_q ? LAST_FAST : LAST_SLOW));
   assign fast_q_o = fast_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         frame_q <= '0;
         fast_q  <= RESET_FAST;
      end else if (wrap_o) begin
         frame_q <= '0;
         fast_q  <= fast_sel_i;
      end else begin
         frame_q <= frame_q + 1'b1;
      end
   end

endmodule

// File: rtl/rcd_div.sv
module rcd_div
   import rcd_pkg::*;
#(
   parameter int P_FAST = 4,
   parameter int P_SLOW = 3,
   parameter int W      = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wrap_i,
   input  logic fast_i,
   output logic hi_o
);

   localparam logic [W-1:0] LAST_FAST = W'(P_FAST - 1);
   localparam logic [W-1:0] LAST_SLOW = W'(P_SLOW - 1);
   localparam logic [W-1:0] HIGH_FAST = W'(high_len(P_FAST));
   localparam logic [W-1:0] HIGH_SLOW = W'(high_len(P_SLOW));

   if (P_FAST < 2 || P_SLOW < 2) begin : g_bad_p
      $error("rcd_div: periods must be at least 2");
   end
   if (P_FAST > (1 << W) || P_SLOW > (1 << W)) begin : g_bad_w
      $error("rcd_div: W too narrow for period");
   end

   logic [W-1:0] cnt_q;
   logic [W-1:0] last;

   assign last = fast_i ? LAST_FAST : LAST_SLOW;
   assign hi_o = (cnt_q < (fast_i ? HIGH_FAST : HIGH_SLOW));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     cnt_q <= '0;
      else if (wrap_i || cnt_q == last) cnt_q <= '0;
      else                             cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/rcd_gate.sv
module rcd_gate #(
   parameter int N = 1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         hi_i,
   input  logic [N-1:0] en_i,
   output logic [N-1:0] q_o
);

   if (N < 1) begin : g_bad_n
      $error("rcd_gate: N must be at least 1");
   end

   logic [N-1:0] gate_q;
   logic [N-1:0] gate_d;

   // the enable is sampled only while the divided phase is low
   for (genvar i = 0; i < N; i++) begin : g_bit
      assign gate_d[i] = hi_i ? gate_q[i] : en_i[i];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gate_q <= '0;
         q_o    <= '0;
      end else begin
         gate_q <= gate_d;
         q_o    <= {N{hi_i}} & gate_d;
      end
   end

endmodule

// File: rtl/ratio_clk_div.sv
module ratio_clk_div
   import rcd_pkg::*;
#(
   parameter int   CODE_W     = 4,
   parameter int   MODE_BIT   = 3,
   parameter int   CPU_BASE   = 2,
   parameter int   N_MID      = 3,
   parameter int   N_PCI      = 10,
   parameter int   N_APIC     = 3,
   parameter logic RESET_FAST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CODE_W-1:0] strap_code_i,
   input  logic [CODE_W-1:0] reg_code_i,
   input  logic              code_src_i,
   input  logic [1:0]        gmode_i,
   input  logic              test_clk_i,
   input  logic              ref_en_i,
   input  logic [N_MID-1:0]  mid_en_i,
   input  logic [N_PCI-1:0]  pci_en_i,
   input  logic [N_APIC-1:0] apic_en_i,
   output logic [CODE_W-1:0] sel_code_o,
   output logic              oe_o,
   output logic              ref_o,
   output logic [N_MID-1:0]  mid_o,
   output logic [N_PCI-1:0]  pci_o,
   output logic [N_APIC-1:0] apic_o
);

   localparam int CNT_W = $clog2(frame_len(1'b1, CPU_BASE));

   if (CPU_BASE < 2 || (CPU_BASE % 2) != 0) begin : g_bad_base
      $error("ratio_clk_div: CPU_BASE must be even and at least 2");
   end
   if (MODE_BIT >= CODE_W) begin : g_bad_bit
      $error("ratio_clk_div: MODE_BIT outside code");
   end
   if (N_MID < 1 || N_PCI < 1 || N_APIC < 1) begin : g_bad_cnt
      $error("ratio_clk_div: each group needs at least one copy");
   end

   gmode_e gm;
   logic   bypass;
   logic   fast_q;
   logic   wrap;
   logic [NGRP-1:0]   hi_grp;
   logic [0:0]        ref_q;
   logic [N_MID-1:0]  mid_q;
   logic [N_PCI-1:0]  pci_q;
   logic [N_APIC-1:0] apic_q;

   assign sel_code_o = code_src_i ? reg_code_i : strap_code_i;
   assign gm         = gmode_e'(gmode_i);
   assign bypass     = (gm == GM_BYPASS);

   rcd_seq #(
      .C          (CPU_BASE),
      .W          (CNT_W),
      .RESET_FAST (RESET_FAST)
   ) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .fast_sel_i (sel_code_o[MODE_BIT]),
      .fast_q_o   (fast_q),
      .wrap_o     (wrap)
   );

   for (genvar g = 0; g < NGRP; g++) begin : g_div
      rcd_div #(
         .P_FAST (grp_period(g, 1'b1, CPU_BASE)),
         .P_SLOW (grp_period(g, 1'b0, CPU_BASE)),
         .W      (CNT_W)
      ) u_div (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .wrap_i (wrap),
         .fast_i (fast_q),
         .hi_o   (hi_grp[g])
      );
   end

   rcd_gate #(.N(1)) u_gate_ref (
      .clk_i (clk_i), .rst_ni (rst_ni), .hi_i (hi_grp[GRP_REF]),
      .en_i  (ref_en_i), .q_o (ref_q)
   );
   rcd_gate #(.N(N_MID)) u_gate_mid (
      .clk_i (clk_i), .rst_ni (rst_ni), .hi_i (hi_grp[GRP_MID]),
      .en_i  (mid_en_i), .q_o (mid_q)
   );
   rcd_gate #(.N(N_PCI)) u_gate_pci (
      .clk_i (clk_i), .rst_ni (rst_ni), .hi_i (hi_grp[GRP_PCI]),
      .en_i  (pci_en_i), .q_o (pci_q)
   );
   rcd_gate #(.N(N_APIC)) u_gate_apic (
      .clk_i (clk_i), .rst_ni (rst_ni), .hi_i (hi_grp[GRP_APIC]),
      .en_i  (apic_en_i), .q_o (apic_q)
   );

   assign ref_o  = bypass ? (test_clk_i & ref_en_i)            : ref_q[0];
   assign mid_o  = bypass ? ({N_MID{test_clk_i}} & mid_en_i)   : mid_q;
   assign pci_o  = bypass ? ({N_PCI{test_clk_i}} & pci_en_i)   : pci_q;
   assign apic_o = bypass ? ({N_APIC{test_clk_i}} & apic_en_i) : apic_q;
   assign oe_o   = (gm != GM_HIZ);

endmodule

// File: rtl/rcd_chk.sv
module rcd_chk #(
   parameter int N_PCI = 10
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             fast_q,
   input logic             wrap,
   input logic [3:0]       hi_grp,
   input logic [N_PCI-1:0] pci_q
);

   // R9: the ratio setting only moves on the last cycle of a frame
   p_mode_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fast_q != $past(fast_q)) |-> $past(wrap));

   // R8: interrupt-rate phase starts together with all faster groups
   p_align_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hi_grp[3]) |-> ($rose(hi_grp[0]) && $rose(hi_grp[1]) && $rose(hi_grp[2])));

   for (genvar i = 0; i < N_PCI; i++) begin : g_pci
      // R7: a gated output rises only at the start of a high phase
      p_rise_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(pci_q[i]) |-> ($past(hi_grp[2]) && !$past(hi_grp[2], 2)));
      // R7: a gated output falls only at the end of a high phase
      p_fall_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $fell(pci_q[i]) |-> !$past(hi_grp[2]));
   end

endmodule

bind ratio_clk_div rcd_chk #(.N_PCI(N_PCI)) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .fast_q (fast_q),
   .wrap   (wrap),
   .hi_grp (hi_grp),
   .pci_q  (pci_q)
);

// File: tb/ratio_clk_div_tb.sv
module ratio_clk_div_tb;

   localparam int CW = 4, N_MID = 3, N_PCI = 10, N_APIC = 3;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [CW-1:0]     strap_code, reg_code, sel_code;
   logic              code_src, test_clk, ref_en, oe, ref_c;
   logic [1:0]        gmode;
   logic [N_MID-1:0]  mid_en, mid_c;
   logic [N_PCI-1:0]  pci_en, pci_c;
   logic [N_APIC-1:0] apic_en, apic_c;

   always #2 clk = ~clk;

   ratio_clk_div u_dut (
      .clk_i (clk), .rst_ni (rst_n), .strap_code_i (strap_code), .reg_code_i (reg_code),
      .code_src_i (code_src), .gmode_i (gmode), .test_clk_i (test_clk), .ref_en_i (ref_en),
      .mid_en_i (mid_en), .pci_en_i (pci_en), .apic_en_i (apic_en), .sel_code_o (sel_code),
      .oe_o (oe), .ref_o (ref_c), .mid_o (mid_c), .pci_o (pci_c), .apic_o (apic_c)
   );

   int n_chk = 0, n_err = 0;

   typedef struct { string req; string what; int val; } exp_t;
   exp_t exp_q[$];

   task automatic push(input string req, input string what, input int v);
      exp_t e;
      e.req = req; e.what = what; e.val = v;
      exp_q.push_back(e);
   endtask

   task automatic pop_cmp(input int act);
      exp_t e;
      n_chk++;
      if (exp_q.size() == 0) begin
         n_err++;
         $display("FAIL scoreboard empty: actual %0d expected none", act);
      end else begin
         e = exp_q.pop_front();
         if (act != e.val) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", e.req, e.what, act, e.val);
         end
      end
   endtask

   int r_ref, h_ref, r_mid, h_mid, r_pci, h_pci, r_apic, h_apic;
   int h_pci2, h_pci3, misalign, runt_bad, runt_seen;

   // samples at falling edges; optional enable toggling on pci copy 1
   task automatic window(input int n, input bit tog, input int exp_high);
      logic p_ref, p_mid, p_pci, p_apic, p1;
      bit rr, rm, rp, inrun;
      int run;
      r_ref = 0; h_ref = 0; r_mid = 0; h_mid = 0; r_pci = 0; h_pci = 0;
      r_apic = 0; h_apic = 0; h_pci2 = 0; h_pci3 = 0; misalign = 0;
      runt_bad = 0; runt_seen = 0; inrun = 0; run = 0;
      @(negedge clk);
      p_ref = ref_c; p_mid = mid_c[0]; p_pci = pci_c[0]; p_apic = apic_c[0]; p1 = pci_c[1];
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         rr = ref_c && !p_ref; rm = mid_c[0] && !p_mid; rp = pci_c[0] && !p_pci;
         if (rr) r_ref++;
         if (ref_c) h_ref++;
         if (rm) r_mid++;
         if (mid_c[0]) h_mid++;
         if (rp) r_pci++;
         if (pci_c[0]) h_pci++;
         if (apic_c[0] && !p_apic) begin
            r_apic++;
            if (!(rr && rm && rp)) misalign++;
         end
         if (apic_c[0]) h_apic++;
         if (pci_c[2]) h_pci2++;
         if (pci_c[3]) h_pci3++;
         if (pci_c[1] && !p1) begin inrun = 1; run = 1; end
         else if (pci_c[1] && inrun) run++;
         else if (!pci_c[1] && p1 && inrun) begin
            runt_seen++;
            if (run != exp_high) runt_bad++;
            inrun = 0;
         end
         p_ref = ref_c; p_mid = mid_c[0]; p_pci = pci_c[0]; p_apic = apic_c[0]; p1 = pci_c[1];
         if (tog && (k % 5) == 2) pci_en[1] = ~pci_en[1];
      end
   endtask

   task automatic wait_cycles(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      #400000;
      n_err++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0; strap_code = 4'b1000; reg_code = 4'b0000; code_src = 1'b0;
      gmode = 2'b00; test_clk = 1'b0; ref_en = 1'b1;
      mid_en = '1; pci_en = '1; apic_en = '1;
      wait_cycles(4);
      // R1: reset state
      push("R1", "ref low in reset", 0);   pop_cmp(int'(ref_c));
      push("R1", "pci low in reset", 0);   pop_cmp(int'(pci_c));
      push("R1", "apic low in reset", 0);  pop_cmp(int'(apic_c));
      push("R1", "oe high in reset", 1);   pop_cmp(int'(oe));
      rst_n = 1'b1;
      pci_en[2] = 1'b0;
      wait_cycles(40);

      // 133 setting from strap code
      push("R5", "strap code selected", 8);   pop_cmp(int'(sel_code));
      window(48, 1'b0, 4);
      push("R2", "ref rises 133", 12);   pop_cmp(r_ref);
      push("R2", "ref highs 133", 24);   pop_cmp(h_ref);
      push("R3", "mid rises", 12);       pop_cmp(r_mid);
      push("R3", "mid highs", 24);       pop_cmp(h_mid);
      push("R3", "pci rises", 6);        pop_cmp(r_pci);
      push("R3", "pci highs", 24);       pop_cmp(h_pci);
      push("R3", "apic rises", 3);       pop_cmp(r_apic);
      push("R3", "apic highs", 24);      pop_cmp(h_apic);
      push("R8", "misaligned apic rises 133", 0); pop_cmp(misalign);
      push("R6", "disabled pci2 highs", 0);       pop_cmp(h_pci2);
      push("R6", "neighbour pci3 highs", 24);     pop_cmp(h_pci3);
      push("R6", "oe while disabled", 1);         pop_cmp(int'(oe));

      // 100 setting from register code, strap still says 133
      reg_code = 4'b0101; code_src = 1'b1;
      #1;
      push("R5", "register code selected", 5);    pop_cmp(int'(sel_code));
      wait_cycles(40);
      window(48, 1'b0, 3);
      push("R2", "ref rises 100", 12);   pop_cmp(r_ref);
      push("R2", "ref highs 100", 24);   pop_cmp(h_ref);
      push("R4", "mid rises", 16);       pop_cmp(r_mid);
      push("R4", "mid highs", 32);       pop_cmp(h_mid);
      push("R4", "pci rises", 8);        pop_cmp(r_pci);
      push("R4", "pci highs", 24);       pop_cmp(h_pci);
      push("R9", "apic rises after switch", 4); pop_cmp(r_apic);
      push("R4", "apic highs", 24);      pop_cmp(h_apic);
      push("R8", "misaligned apic rises 100", 0); pop_cmp(misalign);

      // R7: enable toggling mid-pulse never truncates a pulse
      window(60, 1'b1, 3);
      push("R7", "short or long pulses", 0);      pop_cmp(runt_bad);
      push("R7", "pulses observed", 1);           pop_cmp(int'(runt_seen > 0));
      pci_en[1] = 1'b1;

      // R10: spread mode divides as run mode (strap 133)
      code_src = 1'b0; gmode = 2'b10;
      wait_cycles(40);
      window(48, 1'b0, 4);
      push("R10", "spread ref rises", 12);  pop_cmp(r_ref);
      push("R10", "spread pci rises", 6);   pop_cmp(r_pci);
      push("R10", "spread apic rises", 3);  pop_cmp(r_apic);
      push("R10", "spread oe", 1);          pop_cmp(int'(oe));

      // R11: bypass follows the test clock, gated by enables
      gmode = 2'b01; mid_en[1] = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         test_clk = ~test_clk;
         #1;
         push("R11", "ref follows test clock", int'(test_clk)); pop_cmp(int'(ref_c));
         push("R11", "mid0 follows test clock", int'(test_clk)); pop_cmp(int'(mid_c[0]));
         push("R11", "disabled mid1 low", 0);                   pop_cmp(int'(mid_c[1]));
      end

      // R12: hi-z drops the output enable
      gmode = 2'b11; #1;
      push("R12", "oe in hi-z", 0);   pop_cmp(int'(oe));
      gmode = 2'b00; #1;
      push("R12", "oe back in run", 1); pop_cmp(int'(oe));

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule